// File: doc/BRIEF.md
# Parallel Host Receive Port with Automatic Handshake

This block receives bytes from a host over an 8-bit parallel link and hands them to a local processor. The host places a byte on the data lines and pulses an active-low strobe. When the strobe returns high, the block synchronises the edge, captures the byte, raises the busy line towards the host and raises an interrupt request towards the processor. No firmware is involved in any of these steps.

The processor reads the captured byte through a small register read port. That port has a chip select, a read strobe and a two-bit register select. Reading the data register while a byte is pending clears the interrupt. The same read starts an active-low acknowledge pulse of fixed length on the host side, and busy drops on the edge that ends the pulse.

A strobe that arrives while busy is high does not replace the held byte. Instead it sets a sticky overrun flag, which a read of the status register clears. The eight host data lines can also be read directly, after synchronisation, as a general-purpose preset input port.

Top module: `par_host_rx`

## Requirements
- R1: While `rst` is high on a clock edge, the block returns to its idle state: `host_busy`=0, `host_ack_n`=1, `cpu_irq`=0, `cpu_rdata`=0, no byte pending and overrun clear.
- R2: The block acts only on a low-to-high transition of `host_stb_n`. The first clock edge that samples the strobe high is edge k. At edge k+SYNC_STAGES, provided busy is low, the block captures the data lines as sampled at edge k, and sets `host_busy` and `cpu_irq`. A falling strobe edge does nothing.
- R3: A read access is any clock edge with `cpu_cs`=1 and `cpu_rd`=1. On that edge `cpu_rdata` loads the selected register, and it holds its value between accesses. `cpu_addr`=0 selects the captured byte.
- R4: A data-register read (`cpu_addr`=0) while a byte is pending clears `cpu_irq` on that edge. On the same edge it drives `host_ack_n` low, and `host_ack_n` stays low for exactly ACK_CYCLES clock cycles.
- R5: `host_busy` stays high from the capture until the end of the acknowledge pulse. It falls on the same edge on which `host_ack_n` returns high.
- R6: A qualifying strobe edge (as in R2) that arrives while `host_busy` is high sets the overrun flag. It leaves the captured byte, `cpu_irq` and `host_busy` unchanged.
- R7: `cpu_addr`=1 selects the status register. Its bits are: bit 0 byte pending, bit 1 overrun, bit 2 busy, bit 3 acknowledge active, bits 7..4 zero. A status read clears overrun, except that a new overrun on the same edge wins.
- R8: A data-register read with no byte pending returns the last captured byte. It does not pulse `host_ack_n` and changes neither `cpu_irq` nor `host_busy`.
- R9: `cpu_addr`=2 returns the host data lines as they leave the synchroniser, whatever the strobe is doing. `cpu_addr`=3 returns zero.
- R10: `host_ack_n` is never low while `host_busy` is low, and `cpu_irq` is never high while `host_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_stb_n | input | 1 | Active-low data strobe from the host |
| host_data | input | 8 | Host data lines, also the preset input port |
| host_busy | output | 1 | Busy indication to the host |
| host_ack_n | output | 1 | Active-low acknowledge pulse to the host |
| cpu_irq | output | 1 | Byte-pending interrupt request |
| cpu_cs | input | 1 | Register port chip select |
| cpu_rd | input | 1 | Register port read strobe |
| cpu_addr | input | 2 | Register select: 0 data, 1 status, 2 raw pins, 3 reserved |
| cpu_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with SYNC_STAGES=3 and ACK_CYCLES=8. Three stages exercise a synchroniser longer than the default. The short acknowledge window lets a strobe land inside an acknowledge pulse within a few cycles, so the overrun-during-acknowledge case is reached. A behavioural model driven by a sample queue runs beside the design and is compared on every clock. Directed cases cover a held-low strobe, a double strobe, reads of data with nothing pending, raw pin reads, and a long run of back-to-back bytes.

// File: rtl/phr_pkg.sv
package phr_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_PINS = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] zero;
        logic       ack_act;
        logic       busy;
        logic       ovr;
        logic       pend;
    } stat_t;

    function automatic logic [BYTE_W-1:0] make_stat(input logic pend, input logic ovr,
                                                    input logic busy, input logic ack_act);
        stat_t s;
        s.zero    = '0;
        s.ack_act = ack_act;
        s.busy    = busy;
        s.ovr     = ovr;
        s.pend    = pend;
        return s;
    endfunction

endpackage

// File: rtl/phr_sync_edge.sv
module phr_sync_edge #(
    parameter int STAGES = 2,
    parameter int W      = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_n_in,
    input  logic [W-1:0] data_in,
    output logic         stb_rise,
    output logic [W-1:0] data_out
);
    logic [STAGES-1:0] stb_sr;
    logic [W-1:0]      dat_sr [STAGES];
    logic              stb_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_sr   <= '1;
            stb_prev <= 1'b1;
            for (int i = 0; i < STAGES; i++) dat_sr[i] <= '0;
        end else begin
            stb_sr[0] <= stb_n_in;
            dat_sr[0] <= data_in;
            for (int i = 1; i < STAGES; i++) begin
                stb_sr[i] <= stb_sr[i-1];
                dat_sr[i] <= dat_sr[i-1];
            end
            stb_prev <= stb_sr[STAGES-1];
        end
    end

    assign stb_rise = stb_sr[STAGES-1] & ~stb_prev;
    assign data_out = dat_sr[STAGES-1];

endmodule

// File: rtl/phr_ack_timer.sv
module phr_ack_timer #(
    parameter int CYCLES = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic last
);
    generate
        if (CYCLES <= 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) active <= 1'b0;
                else     active <= start;
            end
            assign last = active;
        end else begin : g_count
            localparam int CW = $clog2(CYCLES);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    active <= 1'b0;
                    cnt    <= '0;
                end else if (start) begin
                    active <= 1'b1;
                    cnt    <= CW'(CYCLES - 1);
                end else if (active) begin
                    if (cnt == '0) active <= 1'b0;
                    else           cnt    <= cnt - 1'b1;
                end
            end
            assign last = active && (cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/phr_rx_ctrl.sv
module phr_rx_ctrl
    import phr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_rise,
    input  logic [BYTE_W-1:0] pin_data,
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic [SEL_W-1:0]  cpu_addr,
    input  logic              ack_active,
    input  logic              ack_last,
    output logic              start_ack,
    output logic              busy,
    output logic              irq,
    output logic [BYTE_W-1:0] rdata
);
    reg_sel_e          sel;
    logic              access, rd_data, rd_stat;
    logic              take, clash;
    logic              busy_q, pend_q, ovr_q;
    logic [BYTE_W-1:0] byte_q, rdata_q, rd_mux;

    assign sel     = reg_sel_e'(cpu_addr);
    assign access  = cpu_cs & cpu_rd;
    assign rd_data = access && (sel == SEL_DATA);
    assign rd_stat = access && (sel == SEL_STAT);
    assign take    = stb_rise & ~busy_q;
    assign clash   = stb_rise &  busy_q;
    assign start_ack = rd_data & pend_q;

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_mux = byte_q;
            SEL_STAT: rd_mux = make_stat(pend_q, ovr_q, busy_q, ack_active);
            SEL_PINS: rd_mux = pin_data;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            ovr_q   <= 1'b0;
            byte_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (take) begin
                byte_q <= pin_data;
                pend_q <= 1'b1;
            end else if (start_ack) begin
                pend_q <= 1'b0;
            end
            if (take)          busy_q <= 1'b1;
            else if (ack_last) busy_q <= 1'b0;
            if (clash)         ovr_q <= 1'b1;
            else if (rd_stat)  ovr_q <= 1'b0;
            if (access)        rdata_q <= rd_mux;
        end
    end

    assign busy  = busy_q;
    assign irq   = pend_q;
    assign rdata = rdata_q;

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && !busy_q) |=> (busy_q && pend_q && byte_q == $past(pin_data)));

    assert_overrun_keeps_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && busy_q) |=> (ovr_q && $stable(byte_q)));

    assert_irq_clear_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_data && pend_q) |=> !pend_q);

    assert_idle_read_no_effect_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !pend_q && !stb_rise) |=> !pend_q);

endmodule

// File: rtl/par_host_rx.sv
module par_host_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_CYCLES  = 80
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_stb_n,
    input  logic [7:0] host_data,
    output logic       host_busy,
    output logic       host_ack_n,
    output logic       cpu_irq,
    input  logic       cpu_cs,
    input  logic       cpu_rd,
    input  logic [1:0] cpu_addr,
    output logic [7:0] cpu_rdata
);
    import phr_pkg::*;

    logic              stb_rise;
    logic [BYTE_W-1:0] pin_data;
    logic              start_ack, ack_active, ack_last;

    phr_sync_edge #(.STAGES(SYNC_STAGES), .W(BYTE_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .stb_n_in (host_stb_n),
        .data_in  (host_data),
        .stb_rise (stb_rise),
        .data_out (pin_data)
    );

    phr_rx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .stb_rise   (stb_rise),
        .pin_data   (pin_data),
        .cpu_cs     (cpu_cs),
        .cpu_rd     (cpu_rd),
        .cpu_addr   (cpu_addr),
        .ack_active (ack_active),
        .ack_last   (ack_last),
        .start_ack  (start_ack),
        .busy       (host_busy),
        .irq        (cpu_irq),
        .rdata      (cpu_rdata)
    );

    phr_ack_timer #(.CYCLES(ACK_CYCLES)) u_ack (
        .clk    (clk),
        .rst    (rst),
        .start  (start_ack),
        .active (ack_active),
        .last   (ack_last)
    );

    assign host_ack_n = ~ack_active;

    assert_ack_starts_R4: assert property (@(posedge clk) disable iff (rst)
        start_ack |=> !host_ack_n);

    assert_busy_falls_with_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(host_busy) |-> $rose(host_ack_n));

    assert_ack_within_busy_R10: assert property (@(posedge clk) disable iff (rst)
        !host_ack_n |-> host_busy);

    assert_irq_within_busy_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> host_busy);

endmodule

// File: tb/tb_par_host_rx.sv
module tb_par_host_rx;
    localparam int CLK_PERIOD = 10;
    localparam int NSYNC      = 3;
    localparam int NACK       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_stb_n = 1'b1;
    logic [7:0] host_data = 8'h00;
    logic       cpu_cs = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic       host_busy, host_ack_n, cpu_irq;
    logic [7:0] cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    par_host_rx #(.SYNC_STAGES(NSYNC), .ACK_CYCLES(NACK)) dut (
        .clk(clk), .rst(rst), .host_stb_n(host_stb_n), .host_data(host_data),
        .host_busy(host_busy), .host_ack_n(host_ack_n), .cpu_irq(cpu_irq),
        .cpu_cs(cpu_cs), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: a queue of sampled strobe/data values
    bit        q_stb[$];
    logic [7:0] q_dat[$];
    bit        m_busy, m_pend, m_ovr, m_ack;
    int        m_left;
    logic [7:0] m_byte, m_rdata;

    always @(posedge clk) begin
        bit rise, rdd, rds, acc;
        logic [7:0] pins, stat;
        if (rst) begin
            q_stb = {}; q_dat = {};
            for (int i = 0; i <= NSYNC; i++) begin q_stb.push_back(1'b1); q_dat.push_back(8'h00); end
            m_busy = 0; m_pend = 0; m_ovr = 0; m_ack = 0; m_left = 0;
            m_byte = 8'h00; m_rdata = 8'h00;
        end else begin
            rise = q_stb[NSYNC-1] && !q_stb[NSYNC];
            pins = q_dat[NSYNC-1];
            acc  = cpu_cs && cpu_rd;
            rdd  = acc && cpu_addr == 2'd0;
            rds  = acc && cpu_addr == 2'd1;
            stat = {4'b0, m_ack, m_busy, m_ovr, m_pend};
            if (acc) m_rdata = (cpu_addr == 2'd0) ? m_byte : (cpu_addr == 2'd1) ? stat :
                               (cpu_addr == 2'd2) ? pins : 8'h00;
            if (rds) m_ovr = 0;
            if (rise && m_busy) m_ovr = 1;
            if (m_ack) begin
                if (m_left == 1) begin m_ack = 0; m_busy = 0; end
                else m_left--;
            end
            if (rdd && m_pend) begin m_pend = 0; m_ack = 1; m_left = NACK; end
            if (rise && !stat[2]) begin m_byte = pins; m_busy = 1; m_pend = 1; end
            q_stb.push_front(host_stb_n); q_dat.push_front(host_data);
            void'(q_stb.pop_back()); void'(q_dat.pop_back());
        end
        #1;
        if (!finished) begin
            chk(host_busy == m_busy, "R5 busy", host_busy, m_busy);
            chk(host_ack_n == !m_ack, "R4 ack_n", host_ack_n, !m_ack);
            chk(cpu_irq == m_pend, "R2 irq", cpu_irq, m_pend);
            chk(cpu_rdata == m_rdata, "R3 rdata", cpu_rdata, m_rdata);
        end
    end

    task automatic host_send(input logic [7:0] b, input int low, input int after);
        @(negedge clk); host_data = b; host_stb_n = 1'b0;
        repeat (low) @(negedge clk);
        host_stb_n = 1'b1;
        repeat (after) @(negedge clk);
    endtask

    task automatic cpu_read(input logic [1:0] a);
        @(negedge clk); cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk); cpu_cs = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle state after reset
        chk(host_busy == 0 && host_ack_n == 1 && cpu_irq == 0 && cpu_rdata == 0, "R1 reset",
            {host_busy, host_ack_n, cpu_irq}, 3'b010);

        // R2 / R3 / R7 basic transfer
        host_send(8'hA5, 3, 8);
        cpu_read(2'd1);
        chk(cpu_rdata == 8'h05, "R7 status pending", cpu_rdata, 8'h05);
        cpu_read(2'd0);
        chk(cpu_rdata == 8'hA5, "R3 data", cpu_rdata, 8'hA5);
        chk(host_ack_n == 0 && cpu_irq == 0, "R4 ack start", {host_ack_n, cpu_irq}, 0);
        cpu_read(2'd1);
        chk(cpu_rdata == 8'h0C, "R7 status during ack", cpu_rdata, 8'h0C);
        idle(10);
        chk(host_busy == 0 && host_ack_n == 1, "R5 busy released", host_busy, 0);

        // R9 raw pins, no strobe
        @(negedge clk); host_data = 8'h3C;
        idle(6);
        cpu_read(2'd2);
        chk(cpu_rdata == 8'h3C, "R9 pins", cpu_rdata, 8'h3C);
        chk(cpu_irq == 0, "R9 no capture", cpu_irq, 0);
        cpu_read(2'd3);
        chk(cpu_rdata == 8'h00, "R9 reserved", cpu_rdata, 0);

        // R8 data read with nothing pending
        cpu_read(2'd0);
        chk(cpu_rdata == 8'hA5 && host_ack_n == 1 && host_busy == 0, "R8 idle read",
            cpu_rdata, 8'hA5);

        // R2 falling edge alone does nothing
        @(negedge clk); host_data = 8'h5A; host_stb_n = 1'b0;
        idle(10);
        chk(cpu_irq == 0 && host_busy == 0, "R2 falling edge ignored", cpu_irq, 0);
        host_stb_n = 1'b1;
        idle(6);
        chk(cpu_irq == 1, "R2 trailing edge", cpu_irq, 1);
        cpu_read(2'd0);
        chk(cpu_rdata == 8'h5A, "R3 data held-low strobe", cpu_rdata, 8'h5A);
        idle(NACK + 3);

        // R6 overrun while waiting for the processor
        host_send(8'h11, 2, 8);
        host_send(8'h22, 2, 8);
        cpu_read(2'd1);
        chk(cpu_rdata == 8'h07, "R6 overrun status", cpu_rdata, 8'h07);
        cpu_read(2'd1);
        chk(cpu_rdata == 8'h05, "R7 overrun cleared", cpu_rdata, 8'h05);
        cpu_read(2'd0);
        chk(cpu_rdata == 8'h11, "R6 byte kept", cpu_rdata, 8'h11);

        // R6 strobe landing inside the acknowledge pulse
        host_send(8'h33, 1, 15);
        cpu_read(2'd1);
        chk(cpu_rdata == 8'h02, "R6 overrun during ack", cpu_rdata, 8'h02);
        cpu_read(2'd0);
        chk(cpu_rdata == 8'h11 && cpu_irq == 0, "R8 byte after dropped strobe", cpu_rdata, 8'h11);
        idle(2);
        chk(host_ack_n == 1, "R8 no ack", host_ack_n, 1);

        // back-to-back traffic
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            b = 8'(i * 37 + 5);
            host_send(b, 1 + (i % 3), 5);
            cpu_read(2'd0);
            chk(cpu_rdata == b, "R3 stream byte", cpu_rdata, b);
            idle(NACK + 1 + (i % 2));
        end

        // R1 reset mid-transfer
        host_send(8'h77, 2, 6);
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        chk(host_busy == 0 && cpu_irq == 0 && cpu_rdata == 0, "R1 reset mid", host_busy, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule